// File: doc/BRIEF.md
# Controller Command Packet Responder

This block sits behind a byte-serial transfer engine in a system management controller. The engine collects a packet from the host and hands it over as a flat byte buffer with a length and a start strobe. The block decodes the packet and builds the reply packet in a flat reply buffer. The reply is announced with a one-cycle valid strobe. The block owns a 32-bit seconds clock counted from 1 January 1904 and an autopoll enable with its poll-rate divider. It also drives two pulse outputs that ask the system to power down or to reset.

A packet whose first byte is 1 is a controller command; its second byte is the command code and any argument bytes follow. Peripheral-bus traffic is not serviced here. When autopoll is on, the block only issues a periodic poll request strobe. When the poll returns data, the block wraps that data in a reply packet. Replies leave byte 0 first. The seconds value is big-endian inside the replies. The seconds clock advances on an external one-second tick enable and starts from `UNIX_INIT + 2082844800`. `RX_BYTES` must be at least 6.

Top module: `cmd_responder`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `poll_req`, `shutdown_req`, `reset_req` and `autopoll_on` are low, and the seconds value is `UNIX_INIT + 2082844800` (mod 2^32).
- R2: `rx_start` is taken only while `busy` is low. It is sampled at edge k. `busy` is then high after edge k; any reply has `tx_valid` high for exactly the cycle after edge k+1. `rx_start` while `busy` is high is ignored.
- R3: The autopoll command is the packet {0x01, 0x01, arg}. It replies {0x01, arg} with length 2. It sets `autopoll_on` to (arg != 0) at the reply edge.
- R4: The set time command is {0x01, 0x09, b3, b2, b1, b0}. It loads the seconds value {b3,b2,b1,b0}, with the first argument byte most significant, at the reply edge. It replies {0x01, 0x00, 0x00} with length 3.
- R5: The get time command is {0x01, 0x03}. It replies with 7 bytes, {0x01, 0x00, 0x00, s[31:24], s[23:16], s[15:8], s[7:0]}. Here s is the seconds value held just before the reply edge.
- R6: Command codes 0x13, 0x14, 0x19 and 0x21 reply {0x01, 0x00} with length 2 and change no state.
- R7: Command 0x0A replies {0x01, 0x00}; `shutdown_req` is then high for exactly the one cycle after the reply cycle. Command 0x11 does the same with `reset_req`. Both pulses are never high together, and `busy` stays high until the pulse edge.
- R8: The following produce no reply and no state change: any other command code, a first byte other than 0x01, a packet shorter than 2 bytes, an autopoll packet shorter than 3 bytes, and a set time packet shorter than 6 bytes.
- R9: The seconds value increments by one, modulo 2^32, on each cycle with `sec_tick` high. A set time load in the same cycle takes precedence over the tick.
- R10: While `autopoll_on` is high, `poll_req` pulses for one cycle every CLK_HZ/POLL_HZ cycles. The first pulse comes that many cycles after the enabling edge. While autopoll is off, `poll_req` stays low.
- R11: `poll_done` with a nonzero `poll_len` while idle produces a reply on the next edge: {0x00, 0x40, data bytes}, with length `poll_len`+2. A zero length produces no reply. `poll_done` while `busy` is high, or in the same cycle as an accepted `rx_start`, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Received packet is ready in `rx_buf` |
| rx_buf | input | RX_BYTES*8 | Received packet, byte i at bits [8i+7:8i] |
| rx_len | input | clog2(RX_BYTES+1) | Received packet length in bytes |
| busy | output | 1 | A packet is being decoded; hold `rx_start` |
| sec_tick | input | 1 | One-second tick enable |
| poll_done | input | 1 | Poll result is ready |
| poll_data | input | POLL_BYTES*8 | Poll result bytes, byte i at bits [8i+7:8i] |
| poll_len | input | clog2(POLL_BYTES+1) | Poll result length, 0 if nothing to report |
| tx_valid | output | 1 | One-cycle strobe: a reply is in `tx_buf` |
| tx_buf | output | TX_BYTES*8 | Reply packet, byte i at bits [8i+7:8i] |
| tx_len | output | clog2(TX_BYTES+1) | Reply length in bytes |
| poll_req | output | 1 | One-cycle poll request strobe |
| autopoll_on | output | 1 | Autopoll enable state |
| shutdown_req | output | 1 | One-cycle power-down request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with CLK_HZ=1000 and POLL_HZ=50. This shrinks the poll period to 20 cycles, so several poll pulses and their phase relative to the enabling edge fit in a short run. POLL_BYTES=5 makes the reply buffer exactly 7 bytes. This exercises both the widest command reply and the widest poll reply at the buffer edge. A nonzero UNIX_INIT shows the epoch shift in the reset seconds value. A set time to 0xFFFFFFFF brings the 32-bit wrap within reach.

// File: rtl/cmdr_pkg.sv
package cmdr_pkg;
  typedef enum logic [1:0] {SIDE_NONE, SIDE_OFF, SIDE_RESET} side_e;
  typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_SIDE} state_e;

  localparam logic [7:0] PKT_BUS    = 8'h00;
  localparam logic [7:0] PKT_CTRL   = 8'h01;
  localparam logic [7:0] POLL_TAG   = 8'h40;

  localparam logic [7:0] OP_AUTOPOLL  = 8'h01;
  localparam logic [7:0] OP_GET_TIME  = 8'h03;
  localparam logic [7:0] OP_SET_TIME  = 8'h09;
  localparam logic [7:0] OP_POWER_OFF = 8'h0A;
  localparam logic [7:0] OP_SYS_RESET = 8'h11;
  localparam logic [7:0] OP_ACK_A     = 8'h13;
  localparam logic [7:0] OP_ACK_B     = 8'h14;
  localparam logic [7:0] OP_ACK_C     = 8'h19;
  localparam logic [7:0] OP_ACK_D     = 8'h21;

  localparam int          REP_MAX     = 7;
  localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;
endpackage

// File: rtl/cmdr_decode.sv
module cmdr_decode import cmdr_pkg::*; #(
  parameter  int RX_BYTES = 8,
  localparam int RXL_W    = $clog2(RX_BYTES + 1)
) (
  input  logic [RX_BYTES*8-1:0] pkt,
  input  logic [RXL_W-1:0]      pkt_len,
  input  logic [31:0]           seconds,
  output logic [REP_MAX*8-1:0]  rep,
  output logic [3:0]            rep_len,
  output logic                  load,
  output logic [31:0]           load_val,
  output logic                  ap_wr,
  output logic                  ap_val,
  output side_e                 side
);
  logic [7:0] b [RX_BYTES];

  for (genvar i = 0; i < RX_BYTES; i++) begin : g_unpack
    assign b[i] = pkt[8*i +: 8];
  end

  always_comb begin
    rep      = '0;
    rep_len  = '0;
    load     = 1'b0;
    load_val = {b[2], b[3], b[4], b[5]};
    ap_wr    = 1'b0;
    ap_val   = (b[2] != 8'h00);
    side     = SIDE_NONE;
    if (int'(pkt_len) >= 2 && b[0] == PKT_CTRL) begin
      rep[7:0] = PKT_CTRL;
      case (b[1])
        OP_AUTOPOLL: if (int'(pkt_len) >= 3) begin
          rep[15:8] = b[2];
          rep_len   = 4'd2;
          ap_wr     = 1'b1;
        end
        OP_SET_TIME: if (int'(pkt_len) >= 6) begin
          rep_len = 4'd3;
          load    = 1'b1;
        end
        OP_GET_TIME: begin
          rep[31:24] = seconds[31:24];
          rep[39:32] = seconds[23:16];
          rep[47:40] = seconds[15:8];
          rep[55:48] = seconds[7:0];
          rep_len    = 4'd7;
        end
        OP_ACK_A, OP_ACK_B, OP_ACK_C, OP_ACK_D: rep_len = 4'd2;
        OP_POWER_OFF: begin
          rep_len = 4'd2;
          side    = SIDE_OFF;
        end
        OP_SYS_RESET: begin
          rep_len = 4'd2;
          side    = SIDE_RESET;
        end
        default: rep_len = 4'd0;
      endcase
    end
  end
endmodule

// File: rtl/cmdr_seconds.sv
module cmdr_seconds #(
  parameter logic [31:0] INIT = 32'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        load,
  input  logic [31:0] load_val,
  output logic [31:0] seconds
);
  always_ff @(posedge clk) begin
    if (rst)       seconds <= INIT;
    else if (load) seconds <= load_val;
    else if (tick) seconds <= seconds + 32'd1;
  end

  // R9: without load or tick the count holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(seconds));
  // R9: a load wins over a tick
  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> (seconds == $past(load_val)));
endmodule

// File: rtl/cmdr_poll_tick.sv
module cmdr_poll_tick #(
  parameter  int DIV = 20,
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (cnt == CW'(DIV - 1)) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: a poll strobe only follows an enabled cycle
  a_r10_needs_enable: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(en));

  if (DIV > 1) begin : g_gap
    // R10: strobes are single-cycle
    a_r10_single: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end
endmodule

// File: rtl/cmd_responder.sv
module cmd_responder import cmdr_pkg::*; #(
  parameter  int          RX_BYTES   = 8,
  parameter  int          POLL_BYTES = 8,
  parameter  int          CLK_HZ     = 50_000_000,
  parameter  int          POLL_HZ    = 50,
  parameter  logic [31:0] UNIX_INIT  = 32'd0,
  localparam int          TX_BYTES   = (POLL_BYTES + 2 > REP_MAX) ? POLL_BYTES + 2 : REP_MAX,
  localparam int          RXL_W      = $clog2(RX_BYTES + 1),
  localparam int          TXL_W      = $clog2(TX_BYTES + 1),
  localparam int          PL_W       = $clog2(POLL_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_start,
  input  logic [RX_BYTES*8-1:0]   rx_buf,
  input  logic [RXL_W-1:0]        rx_len,
  output logic                    busy,
  input  logic                    sec_tick,
  input  logic                    poll_done,
  input  logic [POLL_BYTES*8-1:0] poll_data,
  input  logic [PL_W-1:0]         poll_len,
  output logic                    tx_valid,
  output logic [TX_BYTES*8-1:0]   tx_buf,
  output logic [TXL_W-1:0]        tx_len,
  output logic                    poll_req,
  output logic                    autopoll_on,
  output logic                    shutdown_req,
  output logic                    reset_req
);
  localparam int          POLL_DIV = (CLK_HZ / POLL_HZ > 0) ? CLK_HZ / POLL_HZ : 1;
  localparam logic [31:0] SEC_INIT = UNIX_INIT + EPOCH_SHIFT;

  state_e                 state;
  side_e                  side_q;
  logic [RX_BYTES*8-1:0]  pkt;
  logic [RXL_W-1:0]       pkt_len;
  logic                   ap_q;
  logic [31:0]            seconds;

  logic [REP_MAX*8-1:0]   dec_rep;
  logic [3:0]             dec_len;
  logic                   dec_load;
  logic [31:0]            dec_load_val;
  logic                   dec_ap_wr;
  logic                   dec_ap_val;
  side_e                  dec_side;

  logic [TX_BYTES*8-1:0]  dec_wide;
  logic [TX_BYTES*8-1:0]  poll_rep;
  logic                   in_decode;

  assign in_decode   = (state == ST_DECODE);
  assign busy        = (state != ST_IDLE);
  assign autopoll_on = ap_q;

  cmdr_decode #(.RX_BYTES(RX_BYTES)) u_dec (
    .pkt      (pkt),
    .pkt_len  (pkt_len),
    .seconds  (seconds),
    .rep      (dec_rep),
    .rep_len  (dec_len),
    .load     (dec_load),
    .load_val (dec_load_val),
    .ap_wr    (dec_ap_wr),
    .ap_val   (dec_ap_val),
    .side     (dec_side)
  );

  cmdr_seconds #(.INIT(SEC_INIT)) u_sec (
    .clk      (clk),
    .rst      (rst),
    .tick     (sec_tick),
    .load     (in_decode && dec_load),
    .load_val (dec_load_val),
    .seconds  (seconds)
  );

  cmdr_poll_tick #(.DIV(POLL_DIV)) u_poll (
    .clk  (clk),
    .rst  (rst),
    .en   (ap_q),
    .tick (poll_req)
  );

  always_comb begin
    dec_wide                 = '0;
    dec_wide[REP_MAX*8-1:0]  = dec_rep;
    poll_rep                 = '0;
    poll_rep[7:0]            = PKT_BUS;
    poll_rep[15:8]           = POLL_TAG;
    poll_rep[16 +: POLL_BYTES*8] = poll_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      side_q       <= SIDE_NONE;
      pkt          <= '0;
      pkt_len      <= '0;
      ap_q         <= 1'b0;
      tx_valid     <= 1'b0;
      tx_buf       <= '0;
      tx_len       <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      tx_valid     <= 1'b0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rx_start) begin
            pkt     <= rx_buf;
            pkt_len <= rx_len;
            state   <= ST_DECODE;
          end else if (poll_done && poll_len != '0) begin
            tx_buf   <= poll_rep;
            tx_len   <= TXL_W'(poll_len) + TXL_W'(2);
            tx_valid <= 1'b1;
          end
        end
        ST_DECODE: begin
          if (dec_len != 4'd0) begin
            tx_buf   <= dec_wide;
            tx_len   <= TXL_W'(dec_len);
            tx_valid <= 1'b1;
          end
          if (dec_ap_wr) ap_q <= dec_ap_val;
          side_q <= dec_side;
          state  <= (dec_side == SIDE_NONE) ? ST_IDLE : ST_SIDE;
        end
        ST_SIDE: begin
          shutdown_req <= (side_q == SIDE_OFF);
          reset_req    <= (side_q == SIDE_RESET);
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the two request pulses never coincide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(shutdown_req && reset_req));
  // R7: a request pulse always follows its acknowledge
  a_r7_reply_first: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req || reset_req) |-> $past(tx_valid));
  // R11: a wrapped poll reply carries at least one data byte
  a_r11_poll_shape: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_buf[7:0] == PKT_BUS) |-> (int'(tx_len) >= 3));
  // R2: a start taken while idle always produces a busy cycle
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && rx_start) |=> busy);
endmodule

// File: tb/sim_cmd_responder.sv
module sim_cmd_responder;
  localparam int          RXB   = 8;
  localparam int          PB    = 5;
  localparam int          TXB   = 7;
  localparam int          DIV   = 20;
  localparam logic [31:0] UNIXT = 32'h6000_0000;
  localparam logic [31:0] SINIT = UNIXT + 32'd2082844800;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           rx_start = 1'b0;
  logic [RXB*8-1:0] rx_buf = '0;
  logic [3:0]     rx_len = '0;
  logic           busy;
  logic           sec_tick = 1'b0;
  logic           poll_done = 1'b0;
  logic [PB*8-1:0] poll_data = '0;
  logic [2:0]     poll_len = '0;
  logic           tx_valid;
  logic [TXB*8-1:0] tx_buf;
  logic [2:0]     tx_len;
  logic           poll_req, autopoll_on, shutdown_req, reset_req;

  cmd_responder #(
    .RX_BYTES(RXB), .POLL_BYTES(PB), .CLK_HZ(1000), .POLL_HZ(50), .UNIX_INIT(UNIXT)
  ) u0 (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_buf(rx_buf), .rx_len(rx_len),
    .busy(busy), .sec_tick(sec_tick), .poll_done(poll_done), .poll_data(poll_data),
    .poll_len(poll_len), .tx_valid(tx_valid), .tx_buf(tx_buf), .tx_len(tx_len),
    .poll_req(poll_req), .autopoll_on(autopoll_on), .shutdown_req(shutdown_req),
    .reset_req(reset_req)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string cur_req = "R1";
  logic [7:0] pk[$];

  // reference model state
  int          m_phase = 0;
  int          m_side = 0;
  int          m_pc = 0;
  bit          m_ap = 0;
  logic [31:0] m_sec = SINIT;
  logic [7:0]  m_pkt[$];
  bit          e_valid = 0, e_off = 0, e_rst = 0, e_preq = 0;
  logic [7:0]  exp_b [16];
  int          exp_len = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_rep(input int n, input logic [7:0] b0, input logic [7:0] b1);
    e_valid = 1; exp_len = n; exp_b[0] = b0; exp_b[1] = b1; exp_b[2] = 8'h00;
  endtask

  always @(posedge clk) begin
    logic [31:0] sec_old;
    logic        ld;
    logic [31:0] ldv;
    logic [7:0]  c;
    if (rst) begin
      m_phase = 0; m_side = 0; m_pc = 0; m_ap = 0; m_sec = SINIT;
      e_valid = 0; e_off = 0; e_rst = 0; e_preq = 0;
    end else begin
      sec_old = m_sec; ld = 0; ldv = '0;
      e_valid = 0; e_off = 0; e_rst = 0; e_preq = 0;
      if (!m_ap) m_pc = 0;
      else if (m_pc == DIV - 1) begin m_pc = 0; e_preq = 1; end
      else m_pc++;
      case (m_phase)
        0: begin
          if (rx_start) begin
            m_pkt.delete();
            for (int i = 0; i < int'(rx_len); i++) m_pkt.push_back(rx_buf[8*i +: 8]);
            m_phase = 1;
          end else if (poll_done && poll_len != 0) begin
            e_valid = 1; exp_len = int'(poll_len) + 2;
            exp_b[0] = 8'h00; exp_b[1] = 8'h40;
            for (int i = 0; i < int'(poll_len); i++) exp_b[i+2] = poll_data[8*i +: 8];
          end
        end
        1: begin
          m_phase = 0;
          if (m_pkt.size() >= 2 && m_pkt[0] == 8'h01) begin
            c = m_pkt[1];
            if (c == 8'h01) begin
              if (m_pkt.size() >= 3) begin set_rep(2, 8'h01, m_pkt[2]); m_ap = (m_pkt[2] != 0); end
            end else if (c == 8'h09) begin
              if (m_pkt.size() >= 6) begin
                ld = 1; ldv = {m_pkt[2], m_pkt[3], m_pkt[4], m_pkt[5]};
                set_rep(3, 8'h01, 8'h00);
              end
            end else if (c == 8'h03) begin
              set_rep(7, 8'h01, 8'h00);
              exp_b[3] = sec_old[31:24]; exp_b[4] = sec_old[23:16];
              exp_b[5] = sec_old[15:8];  exp_b[6] = sec_old[7:0];
            end else if (c == 8'h13 || c == 8'h14 || c == 8'h19 || c == 8'h21) begin
              set_rep(2, 8'h01, 8'h00);
            end else if (c == 8'h0A) begin
              set_rep(2, 8'h01, 8'h00); m_side = 1; m_phase = 2;
            end else if (c == 8'h11) begin
              set_rep(2, 8'h01, 8'h00); m_side = 2; m_phase = 2;
            end
          end
        end
        default: begin
          e_off = (m_side == 1); e_rst = (m_side == 2); m_phase = 0;
        end
      endcase
      if (ld) m_sec = ldv;
      else if (sec_tick) m_sec = m_sec + 32'd1;
    end
  end

  always @(posedge clk) begin
    #2;
    cyc++;
    if (!rst) begin
      chk(cur_req, "tx_valid", tx_valid, e_valid);
      if (e_valid) begin
        chk(cur_req, "tx_len", tx_len, exp_len);
        for (int i = 0; i < exp_len; i++) chk(cur_req, "tx_byte", tx_buf[8*i +: 8], exp_b[i]);
      end
      chk(cur_req, "shutdown_req", shutdown_req, e_off);
      chk(cur_req, "reset_req", reset_req, e_rst);
      chk(cur_req, "poll_req", poll_req, e_preq);
      chk(cur_req, "busy", busy, m_phase != 0);
      chk(cur_req, "autopoll_on", autopoll_on, m_ap);
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send_pk();
    @(negedge clk);
    rx_buf = '0;
    foreach (pk[i]) rx_buf[8*i +: 8] = pk[i];
    rx_len = 4'(pk.size());
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_poll(input logic [PB*8-1:0] d, input int n);
    @(negedge clk);
    poll_data = d; poll_len = 3'(n); poll_done = 1'b1;
    @(negedge clk);
    poll_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "busy", busy, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "autopoll_on", autopoll_on, 0);
    pk = '{8'h01, 8'h03}; send_pk();

    cur_req = "R4"; pk = '{8'h01, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78}; send_pk();
    cur_req = "R5"; pk = '{8'h01, 8'h03}; send_pk();
    cur_req = "R9";
    repeat (3) begin @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; end
    pk = '{8'h01, 8'h03}; send_pk();
    pk = '{8'h01, 8'h09, 8'hFF, 8'hFF, 8'hFF, 8'hFF}; send_pk();
    @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
    pk = '{8'h01, 8'h03}; send_pk();
    @(negedge clk); sec_tick = 1'b1;
    pk = '{8'h01, 8'h09, 8'hA5, 8'h00, 8'h00, 8'h01}; send_pk();
    sec_tick = 1'b0;
    pk = '{8'h01, 8'h03}; send_pk();

    cur_req = "R6";
    pk = '{8'h01, 8'h13}; send_pk();
    pk = '{8'h01, 8'h14}; send_pk();
    pk = '{8'h01, 8'h19}; send_pk();
    pk = '{8'h01, 8'h21}; send_pk();

    cur_req = "R7";
    pk = '{8'h01, 8'h0A}; send_pk();
    pk = '{8'h01, 8'h11}; send_pk();

    cur_req = "R8";
    pk = '{8'h01, 8'h02}; send_pk();
    pk = '{8'h00, 8'h03}; send_pk();
    pk = '{8'h02, 8'h03}; send_pk();
    pk = '{8'h01}; send_pk();
    pk = '{8'h01, 8'h09, 8'h00, 8'h00}; send_pk();
    pk = '{8'h01, 8'h01}; send_pk();
    pk = '{8'h01, 8'h03}; send_pk();

    cur_req = "R2";
    @(negedge clk);
    rx_buf = '0; rx_buf[15:0] = 16'h0301; rx_len = 4'd2; rx_start = 1'b1;
    @(negedge clk);
    rx_buf[15:0] = 16'h1301;
    @(negedge clk);
    rx_start = 1'b0;
    repeat (4) @(negedge clk);

    cur_req = "R3"; pk = '{8'h01, 8'h01, 8'h05}; send_pk();
    cur_req = "R10"; repeat (70) @(negedge clk);
    cur_req = "R11";
    do_poll(40'h00_00_CC_BB_AA, 3);
    do_poll(40'h55_44_33_22_11, 5);
    do_poll(40'h00_00_00_00_77, 0);
    @(negedge clk);
    rx_buf = '0; rx_buf[15:0] = 16'h2101; rx_len = 4'd2; rx_start = 1'b1;
    poll_data = 40'h99; poll_len = 3'd1; poll_done = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    @(negedge clk);
    poll_done = 1'b0;
    repeat (4) @(negedge clk);
    cur_req = "R3"; pk = '{8'h01, 8'h01, 8'h00}; send_pk();
    cur_req = "R10"; repeat (50) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule